// File: doc/BRIEF.md
# Character LCD Power-On Initialization Sequencer

After reset this block drives a character LCD from its unconfigured power-on state into 4-bit operation. It then issues the fixed set of configuration commands the display needs before it can take normal traffic. The sequence has two phases.

In the first phase the sequencer owns the 4-bit LCD bus itself. It waits out the power-up delay. It then strobes the nibble 0x3 three times and the nibble 0x2 once. Each strobe has a data setup interval and a fixed-width enable pulse, and the waits between strobes get shorter as the sequence goes on.

In the second phase bus ownership passes to an external byte writer, and the sequencer hands it four command bytes over a valid/ready handshake. After the last command, which clears the display, the sequencer waits out the long execution time of that command. It then raises a done flag that stays high until the next reset.

All intervals are parameters counted in clock cycles. The defaults suit a 50 MHz clock.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset release, `lcd_e_o` stays low for `PWR_CYC + SETUP_CYC` cycles. The first enable pulse then begins.
- R2: In the nibble phase exactly four enable pulses occur, carrying nibbles 0x3, 0x3, 0x3, 0x2 in that order. Before the second, third and fourth pulse setups there are low gaps of `GAP0_CYC`, `GAP1_CYC` and `GAP2_CYC` cycles. `GAP3_CYC` cycles follow the last pulse.
- R3: Each nibble is on `lcd_d_o` for `SETUP_CYC` cycles before its enable rises and for every cycle of the pulse. Every pulse lasts exactly `PULSE_CYC` cycles.
- R4: Throughout the nibble phase, `lcd_rs_o` and `lcd_rw_o` are low and `cmd_valid_o` is low. The byte writer's bus inputs have no effect on the LCD outputs.
- R5: `cmd_valid_o` first rises in the cycle after the gap following the fourth pulse. Bytes 0x28, 0x06, 0x0C and 0x01 are each accepted exactly once, in that order. After the fourth acceptance `cmd_valid_o` stays low.
- R6: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_data_o` is unchanged in the next cycle.
- R7: Once the nibble phase has ended, `lcd_d_o`, `lcd_e_o`, `lcd_rs_o` and `lcd_rw_o` equal the byte writer's `wr_d_i`, `wr_e_i`, `wr_rs_i` and `wr_rw_i`.
- R8: `done_o` rises exactly `CLR_CYC` cycles after the clock edge that accepts byte 0x01. It is low before that, and it stays high until reset.
- R9: Asserting `rst_ni` at any point drops `done_o` and `cmd_valid_o` and restarts the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_o | output | 1 | Command byte offered to byte writer |
| cmd_data_o | output | 8 | Command byte |
| cmd_ready_i | input | 1 | Byte writer can accept a command |
| wr_d_i | input | 4 | Byte writer's nibble bus drive |
| wr_e_i | input | 1 | Byte writer's enable drive |
| wr_rs_i | input | 1 | Byte writer's register-select drive |
| wr_rw_i | input | 1 | Byte writer's read/write drive |
| lcd_d_o | output | 4 | LCD 4-bit data bus |
| lcd_e_o | output | 1 | LCD enable |
| lcd_rs_o | output | 1 | LCD register select |
| lcd_rw_o | output | 1 | LCD read/write |
| done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
A wrong internal state shows up at the pins within one cycle:
- A misloaded interval counter moves an enable edge, so the cycle-exact enable trace differs at the first affected boundary.
- A wrong step index puts a wrong nibble or a wrong byte on the bus during the very setup or handshake it belongs to.
- An ownership select that flips early or late shows up in the first cycle of the mismatch, because the writer inputs are toggled every cycle.
- A step counter that fails to restart shows up after a reset, as a missing or shifted first pulse.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;
  typedef enum logic [2:0] {
    ST_POWER,
    ST_SETUP,
    ST_PULSE,
    ST_GAP,
    ST_CMD,
    ST_CLEAR,
    ST_DONE
  } seq_st_e;

  localparam int NUM_NIB = 4;
  localparam int NUM_CMD = 4;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int CNT_W   = 20,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_init_script.sv
module lcd_init_script #(
  parameter int GAP0_CYC = 205000,
  parameter int GAP1_CYC = 5000,
  parameter int GAP2_CYC = 2000,
  parameter int GAP3_CYC = 2000,
  parameter int CNT_W    = 20
) (
  input  logic [1:0]       nib_idx_i,
  input  logic [1:0]       cmd_idx_i,
  output logic [3:0]       nib_o,
  output logic [7:0]       cmd_o,
  output logic [CNT_W-1:0] gap_len_o
);
  // last strobe selects 4-bit mode, the three before it wake the controller
  assign nib_o = (nib_idx_i == 2'd3) ? 4'h2 : 4'h3;

  always_comb begin
    unique case (cmd_idx_i)
      2'd0:    cmd_o = 8'h28; // 4-bit, two lines, 5x8 font
      2'd1:    cmd_o = 8'h06; // address auto-increment
      2'd2:    cmd_o = 8'h0C; // display on, no cursor, no blink
      default: cmd_o = 8'h01; // clear
    endcase
  end

  always_comb begin
    unique case (nib_idx_i)
      2'd0:    gap_len_o = CNT_W'(GAP0_CYC - 1);
      2'd1:    gap_len_o = CNT_W'(GAP1_CYC - 1);
      2'd2:    gap_len_o = CNT_W'(GAP2_CYC - 1);
      default: gap_len_o = CNT_W'(GAP3_CYC - 1);
    endcase
  end
endmodule

// File: rtl/lcd_init_bus_mux.sv
module lcd_init_bus_mux (
  input  logic       seq_own_i,
  input  logic [3:0] seq_d_i,
  input  logic       seq_e_i,
  input  logic [3:0] wr_d_i,
  input  logic       wr_e_i,
  input  logic       wr_rs_i,
  input  logic       wr_rw_i,
  output logic [3:0] lcd_d_o,
  output logic       lcd_e_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o
);
  always_comb begin
    if (seq_own_i) begin
      lcd_d_o  = seq_d_i;
      lcd_e_o  = seq_e_i;
      lcd_rs_o = 1'b0;
      lcd_rw_o = 1'b0;
    end else begin
      lcd_d_o  = wr_d_i;
      lcd_e_o  = wr_e_i;
      lcd_rs_o = wr_rs_i;
      lcd_rw_o = wr_rw_i;
    end
  end
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int PWR_CYC   = 750000,
  parameter int GAP0_CYC  = 205000,
  parameter int GAP1_CYC  = 5000,
  parameter int GAP2_CYC  = 2000,
  parameter int GAP3_CYC  = 2000,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12,
  parameter int CLR_CYC   = 82000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_data_o,
  input  logic       cmd_ready_i,
  input  logic [3:0] wr_d_i,
  input  logic       wr_e_i,
  input  logic       wr_rs_i,
  input  logic       wr_rw_i,
  output logic [3:0] lcd_d_o,
  output logic       lcd_e_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       done_o
);
  localparam int MAX_GAP = max2(max2(GAP0_CYC, GAP1_CYC), max2(GAP2_CYC, GAP3_CYC));
  localparam int MAX_LEN = max2(max2(PWR_CYC, MAX_GAP), max2(max2(SETUP_CYC, PULSE_CYC), CLR_CYC));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seq_st_e          st_q, st_d;
  logic [1:0]       nib_idx_q, cmd_idx_q;
  logic             nib_adv, cmd_adv;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val, gap_len;
  logic [3:0]       nib;
  logic [7:0]       cmd_byte;
  logic             nib_phase;
  logic             seq_e;
  logic [3:0]       seq_d;

  lcd_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PWR_CYC - 1)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  lcd_init_script #(
    .GAP0_CYC(GAP0_CYC),
    .GAP1_CYC(GAP1_CYC),
    .GAP2_CYC(GAP2_CYC),
    .GAP3_CYC(GAP3_CYC),
    .CNT_W   (CNT_W)
  ) u_script (
    .nib_idx_i(nib_idx_q),
    .cmd_idx_i(cmd_idx_q),
    .nib_o    (nib),
    .cmd_o    (cmd_byte),
    .gap_len_o(gap_len)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    nib_adv  = 1'b0;
    cmd_adv  = 1'b0;
    unique case (st_q)
      ST_POWER: if (tmr_zero) begin
        st_d     = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        st_d     = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_zero) begin
        st_d     = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = gap_len;
      end
      ST_GAP: if (tmr_zero) begin
        if (nib_idx_q == 2'(NUM_NIB - 1)) begin
          st_d = ST_CMD;
        end else begin
          st_d     = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
          nib_adv  = 1'b1;
        end
      end
      ST_CMD: if (cmd_ready_i) begin
        if (cmd_idx_q == 2'(NUM_CMD - 1)) begin
          st_d     = ST_CLEAR;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(CLR_CYC - 1);
        end else begin
          cmd_adv = 1'b1;
        end
      end
      ST_CLEAR: if (tmr_zero) st_d = ST_DONE;
      default:  st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_POWER;
      nib_idx_q <= '0;
      cmd_idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (nib_adv) nib_idx_q <= nib_idx_q + 1'b1;
      if (cmd_adv) cmd_idx_q <= cmd_idx_q + 1'b1;
    end
  end

  assign nib_phase   = (st_q == ST_POWER) || (st_q == ST_SETUP) ||
                       (st_q == ST_PULSE) || (st_q == ST_GAP);
  assign seq_e       = (st_q == ST_PULSE);
  assign seq_d       = (st_q == ST_POWER) ? 4'h0 : nib;
  assign cmd_valid_o = (st_q == ST_CMD);
  assign cmd_data_o  = cmd_valid_o ? cmd_byte : 8'h00;
  assign done_o      = (st_q == ST_DONE);

  lcd_init_bus_mux u_mux (
    .seq_own_i(nib_phase),
    .seq_d_i  (seq_d),
    .seq_e_i  (seq_e),
    .wr_d_i   (wr_d_i),
    .wr_e_i   (wr_e_i),
    .wr_rs_i  (wr_rs_i),
    .wr_rw_i  (wr_rw_i),
    .lcd_d_o  (lcd_d_o),
    .lcd_e_o  (lcd_e_o),
    .lcd_rs_o (lcd_rs_o),
    .lcd_rw_o (lcd_rw_o)
  );
endmodule

// File: rtl/lcd_init_chk.sv
module lcd_init_chk #(
  parameter int PULSE_CYC = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nib_phase_i,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_data_i,
  input logic       cmd_ready_i,
  input logic       lcd_e_i,
  input logic       lcd_rs_i,
  input logic       lcd_rw_i,
  input logic       done_i
);
  localparam int EW = $clog2(PULSE_CYC + 2);
  logic [EW-1:0] e_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            e_run_q <= '0;
    else if (!lcd_e_i)                      e_run_q <= '0;
    else if (e_run_q != EW'(PULSE_CYC + 1)) e_run_q <= e_run_q + 1'b1;
  end

  p_nib_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_phase_i |-> (!lcd_rs_i && !lcd_rw_i && !cmd_valid_i));

  p_pulse_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lcd_e_i) && nib_phase_i) |-> (e_run_q == EW'(PULSE_CYC)));

  p_valid_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_ready_i) |=> (cmd_valid_i && $stable(cmd_data_i)));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);

  p_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!cmd_valid_i && !nib_phase_i));
endmodule

bind lcd_init_seq lcd_init_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nib_phase_i(nib_phase),
  .cmd_valid_i(cmd_valid_o),
  .cmd_data_i (cmd_data_o),
  .cmd_ready_i(cmd_ready_i),
  .lcd_e_i    (lcd_e_o),
  .lcd_rs_i   (lcd_rs_o),
  .lcd_rw_i   (lcd_rw_o),
  .done_i     (done_o)
);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;
  localparam int PWR = 20, G0 = 10, G1 = 6, G2 = 4, G3 = 4;
  localparam int SU = 2, PW = 3, CLR = 15;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [7:0] cmd_data;
  logic [3:0] wr_d = 4'h0, lcd_d;
  logic       wr_e = 1'b0, wr_rs = 1'b0, wr_rw = 1'b0;
  logic       lcd_e, lcd_rs, lcd_rw, done;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcd_init_seq #(
    .PWR_CYC(PWR), .GAP0_CYC(G0), .GAP1_CYC(G1), .GAP2_CYC(G2), .GAP3_CYC(G3),
    .SETUP_CYC(SU), .PULSE_CYC(PW), .CLR_CYC(CLR)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready),
    .wr_d_i(wr_d), .wr_e_i(wr_e), .wr_rs_i(wr_rs), .wr_rw_i(wr_rw),
    .lcd_d_o(lcd_d), .lcd_e_o(lcd_e), .lcd_rs_o(lcd_rs), .lcd_rw_o(lcd_rw),
    .done_o(done)
  );

  function automatic int setup_start(int k);
    int s = PWR;
    int g[4] = '{G0, G1, G2, G3};
    for (int j = 0; j < k; j++) s += SU + PW + g[j];
    return s;
  endfunction

  localparam int T_CMD = 20 + 4 * (2 + 3) + 10 + 6 + 4 + 4;

  function automatic logic [7:0] exp_cmd(int i);
    case (i)
      0: return 8'h28;
      1: return 8'h06;
      2: return 8'h0C;
      default: return 8'h01;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  // abort_at > 0 applies reset at that cycle
  task automatic run_seq(input int rdelay, input int busy, input int abort_at);
    int idx = 0, tacc = -1, bcnt = 0, rises = 0;
    logic prev_e = 1'b0;
    rst_ni = 1'b0;
    cmd_ready = 1'b0;
    @(negedge clk);
    #1;
    chk("R9 done in reset", done, 0, -1);
    chk("R9 valid in reset", cmd_valid, 0, -1);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int t = 0; t < 1000; t++) begin
      wr_d  = 4'(t ^ 5);
      wr_e  = 1'(t);
      wr_rs = 1'(t >> 1);
      wr_rw = 1'(t >> 2);
      if (bcnt > 0) bcnt--;
      cmd_ready = (t >= T_CMD + rdelay) && (bcnt == 0);
      #1;
      if (t < T_CMD) begin
        logic ee = 1'b0;
        logic [3:0] en = 4'h0;
        bit in_win = 1'b0;
        for (int k = 0; k < 4; k++) begin
          int s = setup_start(k);
          if (t >= s + SU && t < s + SU + PW) ee = 1'b1;
          if (t >= s && t < s + SU + PW) begin in_win = 1'b1; en = (k == 3) ? 4'h2 : 4'h3; end
        end
        if (t < PWR + SU) chk("R1 enable low during power-up wait", lcd_e, 0, t);
        else chk("R2 enable trace", lcd_e, ee, t);
        if (in_win) chk("R3 nibble during setup and pulse", lcd_d, en, t);
        if (lcd_e && !prev_e) begin
          rises++;
          chk("R2 nibble at enable rise", lcd_d, (rises == 4) ? 4'h2 : 4'h3, t);
        end
        chk("R4 rs low", lcd_rs, 0, t);
        chk("R4 rw low", lcd_rw, 0, t);
        chk("R4 valid low", cmd_valid, 0, t);
        chk("R8 done low early", done, 0, t);
        prev_e = lcd_e;
      end else begin
        if (t == T_CMD) chk("R2 four pulses", rises, 4, t);
        chk("R7 data follows writer", lcd_d, wr_d, t);
        chk("R7 enable follows writer", lcd_e, wr_e, t);
        chk("R7 rs follows writer", lcd_rs, wr_rs, t);
        chk("R7 rw follows writer", lcd_rw, wr_rw, t);
        if (idx < 4) begin
          chk("R5 valid during command phase", cmd_valid, 1, t);
          chk("R6 command byte", cmd_data, exp_cmd(idx), t);
        end else begin
          chk("R5 no further valid", cmd_valid, 0, t);
        end
        if (tacc >= 0 && t >= tacc + 1 + CLR) chk("R8 done after clear wait", done, 1, t);
        else chk("R8 done low", done, 0, t);
        if (cmd_valid && cmd_ready && idx < 4) begin
          idx++;
          bcnt = busy + 1;
          if (idx == 4) tacc = t;
        end
      end
      if (abort_at > 0 && t == abort_at) break;
      if (tacc >= 0 && t == tacc + CLR + 6) break;
      @(negedge clk);
    end
    if (abort_at == 0) chk("R5 all four accepted", idx, 4, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run_seq(0, 0, 0);
    run_seq(3, 2, 0);
    run_seq(1, 5, T_CMD + 4);
    run_seq(0, 0, 30);
    run_seq(2, 1, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule